// File: doc/BRIEF.md
# Multiscroll Chaos Oscillator with Two-Stage Integration

This block is a free-running digital chaos source. It holds a three-variable state (x, y, z) in signed fixed point and advances it with a midpoint second-order Runge–Kutta integrator. Each step uses two clock cycles. The first cycle forms a half-step state. The second cycle uses the derivatives at that half-step state to form the full step.

The vector field is piecewise linear. Its nonlinearity has two parts: a staircase of step-function terms on y, and a sum of signum terms on z. Two mode inputs select how many terms of each kind are active, one or two. Together they set the scroll count of the attractor to 2m+2n+2 (6, 8 or 10). Every coefficient is a power of two, or a short sum of powers of two, so the datapath uses shifts and adds only.

Each completed step presents the three variables as 14-bit offset-binary codes. Two converter channels carry y and z. An enable input gates these two channels, and they share the core clock. The block is used as a stimulus or noise source feeding a dual-channel DAC.

Top module: `chaos_rk2_gen`

## Requirements
- R1: While rst is high at a rising clock edge, the state is loaded with x=0.25, y=0.125, z=0.25 (Q26: 0x01000000, 0x00800000, 0x01000000), so x_word=0x2040, y_word=0x2020, z_word=0x2040, and step_valid is 0.
- R2: After reset is released, step_valid is high for exactly one cycle in every second cycle. The first pulse follows the second rising edge with rst low.
- R3: Each state value is a 32-bit two's-complement number with 26 fractional bits. One step computes mid = s + (f(s) >>> 10), then s' = s + (f(mid) >>> 9). The shifts are arithmetic on the 48-bit derivative, and the sums wrap to 32 bits. The state changes only in the cycle that raises step_valid.
- R4: The vector field is dx = y, dy = z, dz = 64·(W − x) − 2·y − z + V, evaluated in 48-bit signed arithmetic without wrap.
- R5: W sums 0.25 for each active step term whose condition y ≥ threshold holds. The thresholds are 0.125 and 0.25. Only the first term is active when m_two=0; both are active when m_two=1.
- R6: V sums gain·sgn(z − offset) over the active signum terms, with sgn giving +1, 0 or −1. Term 1 has offset 0.19921875 (Q26 0x00CC0000) and gain 16. Term 2 has offset 0.298828125 (Q26 0x01320000) and gain 32. Only term 1 is active when n_two=0; both are active when n_two=1.
- R7: Each output word is bits [31:18] of the state variable with bit 31 inverted (offset binary).
- R8: dac_ch1 equals y_word and dac_ch2 equals z_word while out_en is 1. Both are 0x2000 while out_en is 0.
- R9: out_en has no effect on the state sequence or on x_word, y_word and z_word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, also the converter sample clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Enables the two converter channels |
| m_two | input | 1 | Selects two step terms instead of one |
| n_two | input | 1 | Selects two signum terms instead of one |
| x_word | output | 14 | Offset-binary code of x |
| y_word | output | 14 | Offset-binary code of y |
| z_word | output | 14 | Offset-binary code of z |
| dac_ch1 | output | 14 | Converter channel 1 (y), midscale when disabled |
| dac_ch2 | output | 14 | Converter channel 2 (z), midscale when disabled |
| step_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench runs long trajectories in each of the four mode combinations and compares every sample against an independent step-by-step model. Because the system is chaotic, a wrong shift amount, a swapped threshold, a missing term or a half-step that reuses the old derivative makes the samples diverge within a few hundred steps. A run that toggles out_en in the middle of a trajectory checks two things. A design that leaks the enable into the state would drift from the model. A design that gates the wrong channel, or gates to zero instead of midscale, would show the wrong converter codes. The bench also checks the exact pulse spacing after reset release, because an off-by-one in the stage sequencing would shift every sample by a cycle.

// File: rtl/cs_pkg.sv
package cs_pkg;

    parameter int STATE_W = 32;
    parameter int FRAC_W  = 26;
    parameter int ACC_W   = 48;
    parameter int TERMS   = 2;
    parameter int D_SHIFT = 6;

    typedef logic signed [STATE_W-1:0] fix_t;
    typedef logic signed [ACC_W-1:0]   acc_t;

    typedef struct packed {
        fix_t x;
        fix_t y;
        fix_t z;
    } state_t;

    typedef struct packed {
        acc_t dx;
        acc_t dy;
        acc_t dz;
    } deriv_t;

    typedef enum logic {PH_HALF, PH_FULL} phase_e;

    localparam acc_t ONE_Q     = acc_t'(1) <<< FRAC_W;
    localparam acc_t STEP_GAIN = ONE_Q >>> 2;
    localparam acc_t THR_B1    = ONE_Q >>> 3;
    localparam acc_t THR_B2    = ONE_Q >>> 2;
    localparam acc_t OFS_C1    = (ONE_Q >>> 3) + (ONE_Q >>> 4) + (ONE_Q >>> 7) + (ONE_Q >>> 8);
    localparam acc_t OFS_C2    = (ONE_Q >>> 2) + (ONE_Q >>> 5) + (ONE_Q >>> 6) + (ONE_Q >>> 9);

    localparam fix_t INIT_X = fix_t'(ONE_Q >>> 2);
    localparam fix_t INIT_Y = fix_t'(ONE_Q >>> 3);
    localparam fix_t INIT_Z = fix_t'(ONE_Q >>> 2);

    function automatic acc_t step_thr(input int j);
        return (j == 0) ? THR_B1 : THR_B2;
    endfunction

    function automatic acc_t sgn_ofs(input int l);
        return (l == 0) ? OFS_C1 : OFS_C2;
    endfunction

    // gains 16 and 32 are formed as shifts of one
    function automatic acc_t sgn_gain(input int l);
        return (l == 0) ? (ONE_Q <<< 4) : (ONE_Q <<< 5);
    endfunction

    function automatic fix_t advance1(input fix_t s, input acc_t k, input int sh);
        acc_t t;
        t = k >>> sh;
        return s + fix_t'(t[STATE_W-1:0]);
    endfunction

    function automatic state_t advance(input state_t s, input deriv_t k, input int sh);
        state_t r;
        r.x = advance1(s.x, k.dx, sh);
        r.y = advance1(s.y, k.dy, sh);
        r.z = advance1(s.z, k.dz, sh);
        return r;
    endfunction

endpackage

// File: rtl/cs_deriv.sv
module cs_deriv
    import cs_pkg::*;
(
    input  state_t s,
    input  logic   m_two,
    input  logic   n_two,
    output deriv_t k
);

    acc_t xs, ys, zs, w, v;

    always_comb begin
        xs = acc_t'(s.x);
        ys = acc_t'(s.y);
        zs = acc_t'(s.z);
        w  = '0;
        v  = '0;
        for (int j = 0; j < TERMS; j++) begin
            if ((j == 0 || m_two) && (ys >= step_thr(j)))
                w = w + STEP_GAIN;
        end
        for (int l = 0; l < TERMS; l++) begin
            if (l == 0 || n_two) begin
                if (zs > sgn_ofs(l))
                    v = v + sgn_gain(l);
                else if (zs < sgn_ofs(l))
                    v = v - sgn_gain(l);
            end
        end
        k.dx = ys;
        k.dy = zs;
        k.dz = ((w - xs) <<< D_SHIFT) - (ys <<< 1) - zs + v;
    end

    // R5: a single active step term can add at most one increment
    always_comb begin
        assert_step_count_R5: assert (m_two || (w <= STEP_GAIN));
    end

endmodule

// File: rtl/cs_word_fmt.sv
module cs_word_fmt #(
    parameter int W     = 32,
    parameter int DAC_W = 14
) (
    input  logic signed [W-1:0] v,
    output logic [DAC_W-1:0]    code
);

    assign code = {~v[W-1], v[W-2 -: DAC_W-1]};

endmodule

// File: rtl/cs_dac_gate.sv
module cs_dac_gate #(
    parameter int DAC_W = 14
) (
    input  logic             en,
    input  logic [DAC_W-1:0] ch1_in,
    input  logic [DAC_W-1:0] ch2_in,
    output logic [DAC_W-1:0] ch1,
    output logic [DAC_W-1:0] ch2
);

    localparam logic [DAC_W-1:0] MIDSCALE = {1'b1, {(DAC_W-1){1'b0}}};

    always_comb begin
        ch1 = en ? ch1_in : MIDSCALE;
        ch2 = en ? ch2_in : MIDSCALE;
    end

endmodule

// File: rtl/chaos_rk2_gen.sv
module chaos_rk2_gen
    import cs_pkg::*;
#(
    parameter int DAC_W    = 14,
    parameter int DT_SHIFT = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_en,
    input  logic             m_two,
    input  logic             n_two,
    output logic [DAC_W-1:0] x_word,
    output logic [DAC_W-1:0] y_word,
    output logic [DAC_W-1:0] z_word,
    output logic [DAC_W-1:0] dac_ch1,
    output logic [DAC_W-1:0] dac_ch2,
    output logic             step_valid
);

    localparam int HALF_SHIFT = DT_SHIFT + 1;
    localparam logic [DAC_W-1:0] MIDSCALE = {1'b1, {(DAC_W-1){1'b0}}};

    state_t st, mid, eval_s;
    deriv_t k;
    phase_e phase;

    assign eval_s = (phase == PH_HALF) ? st : mid;

    cs_deriv u_deriv (
        .s     (eval_s),
        .m_two (m_two),
        .n_two (n_two),
        .k     (k)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '{x: INIT_X, y: INIT_Y, z: INIT_Z};
            mid        <= '{x: INIT_X, y: INIT_Y, z: INIT_Z};
            phase      <= PH_HALF;
            step_valid <= 1'b0;
        end else begin
            case (phase)
                PH_HALF: begin
                    mid        <= advance(st, k, HALF_SHIFT);
                    phase      <= PH_FULL;
                    step_valid <= 1'b0;
                end
                default: begin
                    st         <= advance(st, k, DT_SHIFT);
                    phase      <= PH_HALF;
                    step_valid <= 1'b1;
                end
            endcase
        end
    end

    cs_word_fmt #(.W(STATE_W), .DAC_W(DAC_W)) u_fmt_x (.v(st.x), .code(x_word));
    cs_word_fmt #(.W(STATE_W), .DAC_W(DAC_W)) u_fmt_y (.v(st.y), .code(y_word));
    cs_word_fmt #(.W(STATE_W), .DAC_W(DAC_W)) u_fmt_z (.v(st.z), .code(z_word));

    cs_dac_gate #(.DAC_W(DAC_W)) u_gate (
        .en     (out_en),
        .ch1_in (y_word),
        .ch2_in (z_word),
        .ch1    (dac_ch1),
        .ch2    (dac_ch2)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !step_valid);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        step_valid |=> !step_valid);

    assert_state_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HALF) |=> $stable(st));

    assert_dac_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (dac_ch1 == MIDSCALE && dac_ch2 == MIDSCALE));

    assert_dac_live_R8: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (dac_ch1 == y_word && dac_ch2 == z_word));

endmodule

// File: tb/chaos_rk2_gen_bench.sv
`timescale 1ns/1ps
module chaos_rk2_gen_bench;

    typedef struct {
        logic [13:0] xw;
        logic [13:0] yw;
        logic [13:0] zw;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic out_en = 1'b1;
    logic m_two = 1'b0;
    logic n_two = 1'b0;
    logic [13:0] x_word, y_word, z_word, dac_ch1, dac_ch2;
    logic step_valid;

    int n_checks = 0;
    int n_fail = 0;
    item_t exp_q[$];
    string cur_tag = "";
    int edge_cnt = 0;
    int last_cnt = 0;

    always #2.5 clk = ~clk;

    chaos_rk2_gen u_chaos_rk2_gen (
        .clk(clk), .rst(rst), .out_en(out_en), .m_two(m_two), .n_two(n_two),
        .x_word(x_word), .y_word(y_word), .z_word(z_word),
        .dac_ch1(dac_ch1), .dac_ch2(dac_ch2), .step_valid(step_valid)
    );

    localparam longint ONE = 64'sd1 <<< 26;
    localparam longint B1  = ONE >>> 3;
    localparam longint B2  = ONE >>> 2;
    localparam longint GW  = ONE >>> 2;
    localparam longint C1  = 64'sh00CC0000;
    localparam longint C2  = 64'sh01320000;
    localparam longint A1  = ONE * 16;
    localparam longint A2  = ONE * 32;

    function automatic longint sx(input logic [31:0] v);
        return longint'($signed(v));
    endfunction

    function automatic int sgn(input longint a, input longint b);
        return (a > b) ? 1 : ((a < b) ? -1 : 0);
    endfunction

    // R4 R5 R6: vector field from the stated formulas
    task automatic field(input logic [31:0] s[3], input bit m2, input bit n2,
                         output longint d[3]);
        longint x, y, z, w, v;
        x = sx(s[0]); y = sx(s[1]); z = sx(s[2]);
        w = 0;
        if (y >= B1) w += GW;
        if (m2 && y >= B2) w += GW;
        v = sgn(z, C1) * A1;
        if (n2) v += sgn(z, C2) * A2;
        d[0] = y;
        d[1] = z;
        d[2] = 64 * (w - x) - 2 * y - z + v;
    endtask

    function automatic logic [31:0] adv(input logic [31:0] s, input longint k, input int sh);
        longint t;
        t = sx(s) + (k >>> sh);
        return t[31:0];
    endfunction

    function automatic logic [13:0] word(input logic [31:0] v);
        return {~v[31], v[30:18]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [13:0] act, input logic [13:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // monitor: counts active edges, pops expected samples at each pulse
    always @(posedge clk) begin
        if (rst) edge_cnt <= 0;
        else edge_cnt <= edge_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            last_cnt = 0;
        end else if (step_valid) begin
            item_t e;
            check(edge_cnt - last_cnt == 2, "R2", "pulse spacing",
                  14'(edge_cnt - last_cnt), 14'd2);
            last_cnt = edge_cnt;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected sample", y_word, 14'h0);
            end else begin
                e = exp_q.pop_front();
                check(x_word == e.xw && y_word == e.yw && z_word == e.zw,
                      cur_tag, "x/y/z words", y_word, e.yw);
                if (x_word != e.xw)
                    $display("  x actual %h expected %h", x_word, e.xw);
                if (out_en)
                    check(dac_ch1 == e.yw && dac_ch2 == e.zw, "R8", "enabled channels",
                          dac_ch2, e.zw);
                else
                    check(dac_ch1 == 14'h2000 && dac_ch2 == 14'h2000, "R8",
                          "disabled channels", dac_ch1, 14'h2000);
            end
        end
    end

    // driver: resets, pushes the model trajectory, waits for it to drain
    task automatic run_case(input bit m2, input bit n2, input bit toggle,
                            input int steps, input string tag);
        logic [31:0] s[3], h[3];
        longint d[3];
        int cyc;
        @(posedge clk); #1;
        rst = 1'b1; m_two = m2; n_two = n2; out_en = 1'b1; cur_tag = tag;
        repeat (3) @(posedge clk);
        #1;
        check(x_word == 14'h2040, "R1", "reset x", x_word, 14'h2040);
        check(y_word == 14'h2020, "R1", "reset y", y_word, 14'h2020);
        check(z_word == 14'h2040 && step_valid == 1'b0, "R1", "reset z/valid",
              z_word, 14'h2040);
        s[0] = 32'h01000000; s[1] = 32'h00800000; s[2] = 32'h01000000;
        for (int i = 0; i < steps; i++) begin
            item_t e;
            field(s, m2, n2, d);
            for (int c = 0; c < 3; c++) h[c] = adv(s[c], d[c], 10);
            field(h, m2, n2, d);
            for (int c = 0; c < 3; c++) s[c] = adv(s[c], d[c], 9);
            e.xw = word(s[0]); e.yw = word(s[1]); e.zw = word(s[2]);
            exp_q.push_back(e);
        end
        rst = 1'b0;
        cyc = 0;
        while (exp_q.size() != 0) begin
            @(posedge clk); #1;
            cyc++;
            if (toggle) out_en = ((cyc % 7) < 3); // R9: enable moves mid-run
            if (cyc > 4 * steps + 20) begin
                check(1'b0, tag, "drain timeout", 14'(exp_q.size()), 14'h0);
                exp_q.delete();
            end
        end
    endtask

    initial begin
        run_case(1'b0, 1'b0, 1'b0, 400, "R3 R4 R5 R6 R7 m1n1");
        run_case(1'b1, 1'b0, 1'b0, 400, "R5 m2n1");
        run_case(1'b0, 1'b1, 1'b0, 400, "R6 m1n2");
        run_case(1'b1, 1'b1, 1'b0, 400, "R5 R6 m2n2");
        run_case(1'b1, 1'b1, 1'b1, 300, "R9 toggled enable");
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule